// File: doc/BRIEF.md
# Two-Plane Keyed Alpha Compositor

This block merges one pixel of a graphics plane with one pixel of a video plane into a single RGB output pixel. Both planes are ARGB8888 (alpha in bits 31:24, red 23:16, green 15:8, blue 7:0). A plane-order setting picks the lower plane and the upper plane. The lower plane is composited over black first. The upper plane is then composited over that result.

Each plane has its own settings. These are a blend mode, a global alpha value, a colour key, a key mask and a key mode. Settings are loaded through write strobes and take effect for pixels presented in the cycle after the write. The result is registered. It appears one clock after both input pixels are valid in the same cycle.

Top module: `plane_blend2`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_rgb` is 0.
- R2: After reset, video is the upper plane. Both planes use blend mode none and key mode disabled, with global alpha 0xFF, so the output equals the video pixel's RGB.
- R3: `out_valid` rises one cycle after a cycle in which `gfx_valid` and `vid_valid` are both 1. In any other cycle it is 0 one cycle later, and `out_rgb` keeps its value.
- R4: Blend code 0 (none) makes a plane opaque: its own RGB replaces what lies below it.
- R5: Blend code 1 (global) mixes each channel as (a·c + (255−a)·u + 127)/255, using integer division. Here a is the plane's global alpha, c is the plane's channel and u is the channel of the layer below.
- R6: Blend code 2 (per-pixel) uses the same formula with a taken from bits 31:24 of the plane's own pixel.
- R7: Key code 2 compares the plane's own RGB with its key. On a match the plane is transparent, and the layer below passes through unchanged.
- R8: Key code 1 compares the RGB of the layer below with the key. On a match the plane is transparent. For the lower plane, the layer below is black.
- R9: Only RGB bits set to 1 in the plane's 24-bit mask take part in the key comparison.
- R10: An order write with `ord_top` ≠ `ord_bot` makes the plane named by `ord_top` (0 = graphics, 1 = video) the upper plane. A write with `ord_top` = `ord_bot` is ignored.
- R11: The graphics key mask resets to 0xFFFFFF, and the video key mask and both keys reset to 0. Mode writes and key writes are independent of each other.
- R12: Blend code 3 behaves as none, and key code 3 behaves as disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gfx_valid | input | 1 | Graphics pixel valid |
| gfx_pix | input | 32 | Graphics pixel, ARGB8888 |
| vid_valid | input | 1 | Video pixel valid |
| vid_pix | input | 32 | Video pixel, ARGB8888 |
| gfx_mode_we | input | 1 | Load the graphics blend, key mode and alpha |
| gfx_blend | input | 2 | Graphics blend code |
| gfx_keymode | input | 2 | Graphics key code |
| gfx_alpha | input | 8 | Graphics global alpha |
| gfx_key_we | input | 1 | Load the graphics key and mask |
| gfx_key | input | 24 | Graphics key colour |
| gfx_mask | input | 24 | Graphics key mask |
| vid_mode_we | input | 1 | Load the video blend, key mode and alpha |
| vid_blend | input | 2 | Video blend code |
| vid_keymode | input | 2 | Video key code |
| vid_alpha | input | 8 | Video global alpha |
| vid_key_we | input | 1 | Load the video key and mask |
| vid_key | input | 24 | Video key colour |
| vid_mask | input | 24 | Video key mask |
| ord_we | input | 1 | Plane-order write strobe |
| ord_top | input | 1 | Plane placed on top (0 graphics, 1 video) |
| ord_bot | input | 1 | Plane placed at the bottom |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
Every internal setting feeds only the next output pixel. A wrong plane order, mode, alpha or mask therefore shows up in `out_rgb` on the first valid pixel after the write, one clock after the pixel is presented.

The stimulus values are chosen so that each fault gives a distinct colour:
- A swapped order returns the other plane's colour.
- A lost mask bit turns a non-match into a pass-through.
- An off-by-one in rounding moves a channel by one count.

An accepted equal-order write is caught the same way, because the next pixel comes from the wrong plane.

// File: rtl/plane_blend2.sv
module plane_blend2 #(
  parameter logic [23:0] GFX_MASK_RST = 24'hFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gfx_valid,
  input  logic [31:0] gfx_pix,
  input  logic        vid_valid,
  input  logic [31:0] vid_pix,
  input  logic        gfx_mode_we,
  input  logic [1:0]  gfx_blend,
  input  logic [1:0]  gfx_keymode,
  input  logic [7:0]  gfx_alpha,
  input  logic        gfx_key_we,
  input  logic [23:0] gfx_key,
  input  logic [23:0] gfx_mask,
  input  logic        vid_mode_we,
  input  logic [1:0]  vid_blend,
  input  logic [1:0]  vid_keymode,
  input  logic [7:0]  vid_alpha,
  input  logic        vid_key_we,
  input  logic [23:0] vid_key,
  input  logic [23:0] vid_mask,
  input  logic        ord_we,
  input  logic        ord_top,
  input  logic        ord_bot,
  output logic        out_valid,
  output logic [23:0] out_rgb
);
  logic        top_is_vid;
  logic [1:0]  g_bl, g_km, v_bl, v_km;
  logic [7:0]  g_ga, v_ga;
  logic [23:0] g_key, g_msk, v_key, v_msk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_is_vid <= 1'b1;
      g_bl <= 2'd0; g_km <= 2'd0; g_ga <= 8'hFF;
      v_bl <= 2'd0; v_km <= 2'd0; v_ga <= 8'hFF;
      g_key <= 24'd0; g_msk <= GFX_MASK_RST;
      v_key <= 24'd0; v_msk <= 24'd0;
    end else begin
      if (ord_we && (ord_top != ord_bot)) top_is_vid <= ord_top;
      if (gfx_mode_we) begin g_bl <= gfx_blend; g_km <= gfx_keymode; g_ga <= gfx_alpha; end
      if (vid_mode_we) begin v_bl <= vid_blend; v_km <= vid_keymode; v_ga <= vid_alpha; end
      if (gfx_key_we) begin g_key <= gfx_key; g_msk <= gfx_mask; end
      if (vid_key_we) begin v_key <= vid_key; v_msk <= vid_mask; end
    end
  end

  function automatic logic [23:0] layer(input logic [31:0] px, input logic [23:0] under,
                                        input logic [1:0] bl, input logic [1:0] km,
                                        input logic [7:0] ga, input logic [23:0] key,
                                        input logic [23:0] msk);
    logic [23:0] cmp, r;
    logic        hit;
    logic [7:0]  a;
    logic [15:0] s;
    cmp = (km == 2'd1) ? under : px[23:0];
    hit = ((km == 2'd1) || (km == 2'd2)) && (((cmp ^ key) & msk) == 24'd0);
    a   = (bl == 2'd1) ? ga : (bl == 2'd2) ? px[31:24] : 8'hFF;
    r   = 24'd0;
    for (int i = 0; i < 3; i++) begin
      s = 16'(a) * 16'(px[8*i +: 8]) + 16'(8'hFF - a) * 16'(under[8*i +: 8]) + 16'd127;
      r[8*i +: 8] = 8'(s / 16'd255);
    end
    return hit ? under : r;
  endfunction

  logic [31:0] bot_px, top_px;
  logic [23:0] mid_rgb, fin_rgb;

  assign bot_px  = top_is_vid ? gfx_pix : vid_pix;
  assign top_px  = top_is_vid ? vid_pix : gfx_pix;
  assign mid_rgb = top_is_vid ? layer(bot_px, 24'd0, g_bl, g_km, g_ga, g_key, g_msk)
                              : layer(bot_px, 24'd0, v_bl, v_km, v_ga, v_key, v_msk);
  assign fin_rgb = top_is_vid ? layer(top_px, mid_rgb, v_bl, v_km, v_ga, v_key, v_msk)
                              : layer(top_px, mid_rgb, g_bl, g_km, g_ga, g_key, g_msk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= 24'd0;
    end else begin
      out_valid <= gfx_valid & vid_valid;
      if (gfx_valid && vid_valid) out_rgb <= fin_rgb;
    end
  end
endmodule

// File: rtl/plane_blend2_chk.sv
module plane_blend2_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gfx_valid,
  input logic        vid_valid,
  input logic [31:0] vid_pix,
  input logic        ord_we,
  input logic        ord_top,
  input logic        ord_bot,
  input logic        top_is_vid,
  input logic [1:0]  v_bl,
  input logic [1:0]  v_km,
  input logic        out_valid,
  input logic [23:0] out_rgb
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_rgb == 24'd0)); // R1
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_valid && vid_valid) |=> out_valid); // R3
  AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(gfx_valid && vid_valid) |=> (!out_valid && $stable(out_rgb))); // R3
  AST_ORDER_EQUAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_we && ord_top == ord_bot) |=> $stable(top_is_vid)); // R10
  AST_ORDER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_we && ord_top != ord_bot) |=> (top_is_vid == $past(ord_top))); // R10
  AST_TOP_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_valid && vid_valid && top_is_vid && v_km == 2'd0 && v_bl == 2'd0)
      |=> (out_rgb == $past(vid_pix[23:0]))); // R4
endmodule

bind plane_blend2 plane_blend2_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gfx_valid(gfx_valid), .vid_valid(vid_valid),
  .vid_pix(vid_pix), .ord_we(ord_we), .ord_top(ord_top), .ord_bot(ord_bot),
  .top_is_vid(top_is_vid), .v_bl(v_bl), .v_km(v_km),
  .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/tb_plane_blend2.sv
module tb_plane_blend2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic gfx_valid = 0, vid_valid = 0;
  logic [31:0] gfx_pix = 0, vid_pix = 0;
  logic gfx_mode_we = 0, gfx_key_we = 0, vid_mode_we = 0, vid_key_we = 0;
  logic [1:0] gfx_blend = 0, gfx_keymode = 0, vid_blend = 0, vid_keymode = 0;
  logic [7:0] gfx_alpha = 0, vid_alpha = 0;
  logic [23:0] gfx_key = 0, gfx_mask = 0, vid_key = 0, vid_mask = 0;
  logic ord_we = 0, ord_top = 0, ord_bot = 0;
  logic out_valid;
  logic [23:0] out_rgb;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  plane_blend2 dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mix(input logic [7:0] a, input logic [23:0] c, input logic [23:0] u);
    logic [23:0] r;
    for (int i = 0; i < 3; i++)
      r[8*i +: 8] = 8'((int'(a) * int'(c[8*i +: 8]) + (255 - int'(a)) * int'(u[8*i +: 8]) + 127) / 255);
    return r;
  endfunction

  task automatic set_mode(input bit vid, input logic [1:0] bl, input logic [1:0] km, input logic [7:0] a);
    @(negedge clk);
    if (vid) begin vid_mode_we = 1; vid_blend = bl; vid_keymode = km; vid_alpha = a; end
    else     begin gfx_mode_we = 1; gfx_blend = bl; gfx_keymode = km; gfx_alpha = a; end
    @(negedge clk);
    vid_mode_we = 0; gfx_mode_we = 0;
  endtask

  task automatic set_key(input bit vid, input logic [23:0] k, input logic [23:0] m);
    @(negedge clk);
    if (vid) begin vid_key_we = 1; vid_key = k; vid_mask = m; end
    else     begin gfx_key_we = 1; gfx_key = k; gfx_mask = m; end
    @(negedge clk);
    vid_key_we = 0; gfx_key_we = 0;
  endtask

  task automatic set_order(input bit top, input bit bot);
    @(negedge clk);
    ord_we = 1; ord_top = top; ord_bot = bot;
    @(negedge clk);
    ord_we = 0;
  endtask

  task automatic send(input logic [31:0] g, input logic [31:0] v, input string req, input logic [23:0] exp);
    @(negedge clk);
    gfx_pix = g; vid_pix = v; gfx_valid = 1; vid_valid = 1;
    @(negedge clk);
    gfx_valid = 0; vid_valid = 0;
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {8'd0, out_rgb}, {8'd0, exp});
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 rgb in reset", {8'd0, out_rgb}, 32'd0);
    @(negedge clk); rst_n = 1;
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_default();
    send(32'h80112233, 32'h40AABBCC, "R2 video on top opaque", 24'hAABBCC);
  endtask

  task automatic t_valid();
    @(negedge clk);
    gfx_pix = 32'h00123456; vid_pix = 32'h00654321; gfx_valid = 1; vid_valid = 0;
    @(negedge clk);
    chk("R3 only gfx valid", {31'd0, out_valid}, 32'd0);
    chk("R3 rgb held", {8'd0, out_rgb}, 32'h00AABBCC);
    gfx_valid = 0; vid_valid = 1;
    @(negedge clk);
    vid_valid = 0;
    chk("R3 only vid valid", {31'd0, out_valid}, 32'd0);
    chk("R3 rgb held 2", {8'd0, out_rgb}, 32'h00AABBCC);
  endtask

  task automatic t_global();
    set_mode(1, 2'd1, 2'd0, 8'h40);
    send(32'h000000FF, 32'h00FF0000, "R5 global alpha", mix(8'h40, 24'hFF0000, 24'h0000FF));
    send(32'h00808080, 32'h00102030, "R5 global alpha 2", mix(8'h40, 24'h102030, 24'h808080));
  endtask

  task automatic t_pixel();
    set_mode(1, 2'd2, 2'd0, 8'h00);
    send(32'h00204060, 32'hC0F0E0D0, "R6 per-pixel alpha", mix(8'hC0, 24'hF0E0D0, 24'h204060));
  endtask

  task automatic t_bottom();
    set_mode(1, 2'd0, 2'd0, 8'hFF);
    set_mode(0, 2'd1, 2'd0, 8'h80);
    set_order(1'b0, 1'b1);
    send(32'h00AABBCC, 32'h00FF00FF, "R4 gfx on top opaque? no, global", mix(8'h80, 24'hAABBCC, 24'hFF00FF));
    set_order(1'b1, 1'b0);
    send(32'h00FFFFFF, 32'h80000000, "R4 video opaque over gfx", 24'h000000);
    set_mode(1, 2'd1, 2'd0, 8'h00);
    send(32'h00FFFFFF, 32'h00000000, "R5 bottom over black", mix(8'h80, 24'hFFFFFF, 24'h000000));
    set_mode(1, 2'd0, 2'd0, 8'hFF);
    set_mode(0, 2'd0, 2'd0, 8'hFF);
  endtask

  task automatic t_mask_reset();
    set_order(1'b0, 1'b1);
    set_mode(0, 2'd0, 2'd2, 8'hFF);
    send(32'h00000001, 32'h00777777, "R11 gfx mask reset all ones", 24'h000001);
    send(32'h00000000, 32'h00777777, "R7 own key match", 24'h777777);
  endtask

  task automatic t_keys();
    set_key(0, 24'h112233, 24'hFFFF00);
    send(32'h001122EE, 32'h00555555, "R9 masked low byte ignored", 24'h555555);
    send(32'h001133EE, 32'h00555555, "R9 unmasked bit differs", 24'h1133EE);
    set_mode(0, 2'd0, 2'd1, 8'hFF);
    set_key(0, 24'h555555, 24'hFFFFFF);
    send(32'h00ABCDEF, 32'h00555555, "R8 lower-layer key match", 24'h555555);
    send(32'h00555555, 32'h00555556, "R8 own pixel not compared", 24'h555555);
    set_mode(0, 2'd0, 2'd3, 8'hFF);
    set_key(0, 24'hABCDEF, 24'hFFFFFF);
    send(32'h00ABCDEF, 32'h00010203, "R12 key code 3 disabled", 24'hABCDEF);
    set_mode(0, 2'd3, 2'd0, 8'h10);
    send(32'h00ABCDEF, 32'h00010203, "R12 blend code 3 opaque", 24'hABCDEF);
  endtask

  task automatic t_order();
    set_mode(0, 2'd0, 2'd0, 8'hFF);
    set_order(1'b1, 1'b1);
    send(32'h00111111, 32'h00222222, "R10 equal order ignored", 24'h111111);
    set_order(1'b1, 1'b0);
    send(32'h00111111, 32'h00222222, "R10 video to top", 24'h222222);
    set_order(1'b0, 1'b0);
    send(32'h00111111, 32'h00222222, "R10 equal order ignored 2", 24'h222222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_default();
    t_valid();
    t_global();
    t_pixel();
    t_bottom();
    t_mask_reset();
    t_keys();
    t_order();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule